// File: doc/BRIEF.md
# Interrupt Request and Service Core

This block is the request-tracking and acknowledge engine of an eight-line interrupt controller. It watches eight raw request pins and records a request only when a pin goes from low to high. A line whose mask bit is set at that moment loses its request for good; the request is not held back for later. It keeps a pending-request register and an in-service register. Each time a request qualifies, it sends the processor a one-cycle interrupt pulse. A request qualifies only when no line of equal or higher number is in service.

A separate command decoder supplies the mask, the vector base, the cascade map, the slave-present flag and the automatic end-of-service setting. When the processor strobes acknowledge, the core picks the highest-numbered pending line. It returns that line's vector one cycle later. If that line leads to an attached secondary controller, it raises a select flag so that external logic fetches the vector from that controller. End-of-service strobes retire in-service bits, either a named line or the highest one. After each such strobe the core checks again whether the top pending request may now interrupt.

The vector output is a valid-only stream. `vec_valid_o` is high for exactly one cycle, and the block offers no back-pressure: the consumer must take the vector in that cycle. All other pins are plain control and status signals.

Top module: `irq_service_core`

## Requirements
- R1: A request is recorded only on a low-to-high change of a pin, compared with the pin value stored in the previous cycle. A pin held high records nothing more. The stored pin values reset to all ones, so a pin that is already high when reset is released records nothing.
- R2: A rising edge on a line whose `mask_i` bit is 1 in that cycle is discarded. Clearing the mask later, while the pin stays high, does not record the request.
- R3: An unmasked rising edge on line L sets `pending_o[L]` in the next cycle. `irq_o` pulses high for exactly that cycle only if `in_service_o[7:L]` is all zero.
- R4: An acknowledge serves the highest-numbered pending line: line 7 has the highest priority and line 0 the lowest.
- R5: An acknowledge clears the served line's pending bit. With `auto_eoi_i`=0 it sets that line's in-service bit. With `auto_eoi_i`=1 it leaves the in-service register unchanged and runs the re-check of R8.
- R6: One cycle after `ack_i`, `vec_valid_o` is high for one cycle. `vec_o` is then {`vec_base_i`, 3-bit line number}, with the base in bits 7:3.
- R7: `slave_sel_o` goes high together with the vector when the served line's `cascade_map_i` bit is 1 and `slave_present_i` is 1. Otherwise it is 0.
- R8: An `eoi_i` strobe clears `in_service_o[eoi_line_i]` when `eoi_specific_i`=1, and the highest set in-service bit when `eoi_specific_i`=0. If a request is still pending afterwards, `irq_o` pulses in the next cycle when the in-service bits from the top pending line upward are all zero.
- R9: An acknowledge with nothing pending returns `vec_o` = {base, 3'b111} with `slave_sel_o`=0. It leaves the pending and in-service registers unchanged.
- R10: After reset, `pending_o`, `in_service_o`, `irq_o`, `vec_valid_o` and `slave_sel_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_pins_i | input | 8 | Raw request pins, one per line |
| mask_i | input | 8 | Per-line mask, 1 discards edges |
| vec_base_i | input | 5 | Upper vector bits |
| cascade_map_i | input | 8 | 1 marks a line that leads to a secondary controller |
| slave_present_i | input | 1 | A secondary controller is attached |
| auto_eoi_i | input | 1 | Retire service automatically on acknowledge |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| eoi_i | input | 1 | One-cycle end-of-service strobe |
| eoi_specific_i | input | 1 | 1: retire `eoi_line_i`; 0: retire the highest in-service line |
| eoi_line_i | input | 3 | Line to retire when the strobe names a line |
| irq_o | output | 1 | One-cycle interrupt pulse to the processor |
| vec_valid_o | output | 1 | Vector valid, one cycle |
| vec_o | output | 8 | Returned vector |
| slave_sel_o | output | 1 | Vector must come from the secondary controller |
| pending_o | output | 8 | Pending-request register |
| in_service_o | output | 8 | In-service register |

## Verification
A corrupt pending or in-service bit appears on `pending_o` or `in_service_o` in the cycle after the event that caused it. It also changes which line the next acknowledge serves, and so the low three bits of `vec_o` one cycle after that strobe. A wrong ceiling comparison shows as a missing or extra `irq_o` pulse in the cycle right after the edge or the end-of-service strobe. The directed scenarios therefore build nested service states: a lower line held back by a higher in-service line, released by a specific retirement, and automatic retirement with a request still waiting. In each of them the pulses and vectors are checked in that exact cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINES  = 8;
  localparam int unsigned LINE_W = $clog2(LINES);
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned BASE_W = VEC_W - LINE_W;

  typedef logic [LINES-1:0]  line_vec_t;
  typedef logic [LINE_W-1:0] line_idx_t;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] accepted_o
);
  logic [N-1:0] prev_q;

  // Stored pin state resets high: a pin already high at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= pins_i;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      assign accepted_o[g] = pins_i[g] & ~prev_q[g] & ~mask_i[g];
    end
  endgenerate
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] top_o
);
  always_comb begin
    top_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) top_o = W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irqc_ceiling.sv
module irqc_ceiling #(
  parameter int unsigned N = 8,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] in_service_i,
  input  logic [W-1:0] line_i,
  output logic         clear_o
);
  logic [N-1:0] at_or_above;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign at_or_above[g] = (W'(g) >= line_i);
    end
  endgenerate

  assign clear_o = ~|(in_service_i & at_or_above);
endmodule

// File: rtl/irq_service_core.sv
module irq_service_core
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  req_pins_i,
  input  logic [LINES-1:0]  mask_i,
  input  logic [BASE_W-1:0] vec_base_i,
  input  logic [LINES-1:0]  cascade_map_i,
  input  logic              slave_present_i,
  input  logic              auto_eoi_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  input  logic              eoi_specific_i,
  input  logic [LINE_W-1:0] eoi_line_i,
  output logic              irq_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              slave_sel_o,
  output logic [LINES-1:0]  pending_o,
  output logic [LINES-1:0]  in_service_o
);
  line_vec_t pend_q, isr_q, pend_n, isr_n;
  line_vec_t accepted;

  // Rising-edge capture with mask filtering
  irqc_edge #(.N(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pins_i(req_pins_i), .mask_i(mask_i),
    .accepted_o(accepted)
  );

  // Priority finders: new edges, pending set, in-service set, next pending set
  logic      new_any, pend_any, isr_any, re_any;
  line_idx_t new_top, pend_top, isr_top, re_top;

  irqc_prio #(.N(LINES), .W(LINE_W)) u_prio_new (
    .req_i(accepted), .any_o(new_any), .top_o(new_top));
  irqc_prio #(.N(LINES), .W(LINE_W)) u_prio_pend (
    .req_i(pend_q), .any_o(pend_any), .top_o(pend_top));
  irqc_prio #(.N(LINES), .W(LINE_W)) u_prio_isr (
    .req_i(isr_q), .any_o(isr_any), .top_o(isr_top));
  irqc_prio #(.N(LINES), .W(LINE_W)) u_prio_re (
    .req_i(pend_n), .any_o(re_any), .top_o(re_top));

  // Service ceilings: a new edge is checked against the current in-service
  // set, a re-check against the in-service set after this cycle's updates.
  logic new_clear, re_clear;
  irqc_ceiling #(.N(LINES), .W(LINE_W)) u_ceil_new (
    .in_service_i(isr_q), .line_i(new_top), .clear_o(new_clear));
  irqc_ceiling #(.N(LINES), .W(LINE_W)) u_ceil_re (
    .in_service_i(isr_n), .line_i(re_top), .clear_o(re_clear));

  line_vec_t ack_clr, ack_set, eoi_clr;
  logic      recheck, irq_n, sel_n;
  logic [VEC_W-1:0] vec_n;

  always_comb begin
    ack_clr = '0;
    ack_set = '0;
    eoi_clr = '0;
    recheck = 1'b0;
    sel_n   = 1'b0;
    vec_n   = {vec_base_i, {LINE_W{1'b1}}};

    if (ack_i && pend_any) begin
      ack_clr[pend_top] = 1'b1;
      vec_n = {vec_base_i, pend_top};
      sel_n = cascade_map_i[pend_top] & slave_present_i;
      if (auto_eoi_i) recheck = 1'b1;
      else            ack_set[pend_top] = 1'b1;
    end

    if (eoi_i) begin
      recheck = 1'b1;
      if (eoi_specific_i)  eoi_clr[eoi_line_i] = 1'b1;
      else if (isr_any)    eoi_clr[isr_top]    = 1'b1;
    end

    pend_n = (pend_q & ~ack_clr) | accepted;
    isr_n  = (isr_q & ~eoi_clr) | ack_set;
    irq_n  = (new_any & new_clear) | (recheck & re_any & re_clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      isr_q       <= '0;
      irq_o       <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      slave_sel_o <= 1'b0;
    end else begin
      pend_q      <= pend_n;
      isr_q       <= isr_n;
      irq_o       <= irq_n;
      vec_valid_o <= ack_i;
      if (ack_i) begin
        vec_o       <= vec_n;
        slave_sel_o <= sel_n;
      end else begin
        slave_sel_o <= 1'b0;
      end
    end
  end

  assign pending_o    = pend_q;
  assign in_service_o = isr_q;

  // Assertions guarding the registers above
  AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o); // R6
  AST_NO_STRAY_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o); // R6
  AST_MASKED_NOT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pending_o & ~$past(pending_o) & $past(mask_i)) == '0)); // R2
  AST_SLAVE_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> (!slave_sel_o || $past(slave_present_i))); // R7
  AST_SPECIFIC_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && eoi_specific_i && !ack_i) |=> !in_service_o[$past(eoi_line_i)]); // R8
  AST_AUTO_EOI_NO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi_i && !eoi_i) |=>
      ($countones(in_service_o) == $countones($past(in_service_o)))); // R5
endmodule

// File: tb/irq_service_core_bench.sv
module irq_service_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = '0, mask = '0, cmap = '0;
  logic [4:0] base = 5'b01000;
  logic       spres = 1'b0, aeoi = 1'b0, ack = 1'b0, eoi = 1'b0, espec = 1'b0;
  logic [2:0] eline = '0;
  logic       irq, vvalid, ssel;
  logic [7:0] vec, pend, isr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_service_core u_irq_service_core (
    .clk(clk), .rst_n(rst_n), .req_pins_i(pins), .mask_i(mask),
    .vec_base_i(base), .cascade_map_i(cmap), .slave_present_i(spres),
    .auto_eoi_i(aeoi), .ack_i(ack), .eoi_i(eoi), .eoi_specific_i(espec),
    .eoi_line_i(eline), .irq_o(irq), .vec_valid_o(vvalid), .vec_o(vec),
    .slave_sel_o(ssel), .pending_o(pend), .in_service_o(isr));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic raise(input int l);
    pins[l] = 1'b1;
    step();
  endtask

  task automatic lower(input int l);
    pins[l] = 1'b0;
    step();
  endtask

  task automatic do_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic do_eoi(input logic spec, input logic [2:0] l);
    eoi = 1'b1; espec = spec; eline = l;
    step();
    eoi = 1'b0;
  endtask

  task automatic t_reset();
    pins[0] = 1'b1;
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R10 pending", pend, 8'h00);
    chk("R10 in_service", isr, 8'h00);
    chk("R10 irq/valid/sel", {5'b0, irq, vvalid, ssel}, 8'h00);
    chk("R1 high across reset not an edge", pend, 8'h00);
    lower(0);
  endtask

  task automatic t_edge();
    raise(3);
    chk("R3 irq on edge", {7'b0, irq}, 8'h01);
    chk("R3 pending set", pend, 8'h08);
    step();
    chk("R3 irq one cycle", {7'b0, irq}, 8'h00);
    chk("R1 held high no new request", pend, 8'h08);
    lower(3);
  endtask

  task automatic t_mask();
    mask[5] = 1'b1;
    raise(5);
    chk("R2 masked edge no irq", {7'b0, irq}, 8'h00);
    chk("R2 masked edge dropped", pend, 8'h08);
    mask[5] = 1'b0;
    step();
    chk("R2 unmask while high not latched", pend, 8'h08);
    lower(5);
  endtask

  task automatic t_priority();
    raise(6);
    chk("R3 higher edge irq", {7'b0, irq}, 8'h01);
    lower(6);
    do_ack();
    chk("R6 vec valid", {7'b0, vvalid}, 8'h01);
    chk("R4 top line served", vec, 8'h46);
    chk("R5 pending cleared", pend, 8'h08);
    chk("R5 in_service set", isr, 8'h40);
    step();
    chk("R6 valid one cycle", {7'b0, vvalid}, 8'h00);
    do_ack();
    chk("R4 next line served", vec, 8'h43);
    chk("R5 in_service both", isr, 8'h48);
  endtask

  task automatic t_ceiling();
    raise(2);
    chk("R3 blocked by higher service", {7'b0, irq}, 8'h00);
    lower(2);
    raise(7);
    chk("R3 line 7 above service", {7'b0, irq}, 8'h01);
    lower(7);
    do_eoi(1'b0, 3'd0);
    chk("R8 nonspecific clears top", isr, 8'h08);
    chk("R8 recheck raises irq", {7'b0, irq}, 8'h01);
    do_ack();
    chk("R4 line 7 served", vec, 8'h47);
    do_eoi(1'b1, 3'd3);
    chk("R8 specific clears line 3", isr, 8'h80);
    chk("R8 recheck blocked", {7'b0, irq}, 8'h00);
    do_eoi(1'b1, 3'd7);
    chk("R8 recheck released", {7'b0, irq}, 8'h01);
    do_ack();
    chk("R6 vector line 2", vec, 8'h42);
    do_eoi(1'b0, 3'd0);
    chk("R8 all retired", isr, 8'h00);
    chk("R8 no pending no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_auto();
    aeoi = 1'b1;
    raise(4); lower(4);
    raise(1);
    chk("R3 lower edge with empty service", {7'b0, irq}, 8'h01);
    lower(1);
    do_ack();
    chk("R5 auto vector", vec, 8'h44);
    chk("R5 auto no in_service", isr, 8'h00);
    chk("R5 auto recheck irq", {7'b0, irq}, 8'h01);
    do_ack();
    chk("R5 auto second vector", vec, 8'h41);
    chk("R5 auto pending empty", pend, 8'h00);
    chk("R5 auto no recheck", {7'b0, irq}, 8'h00);
    aeoi = 1'b0;
  endtask

  task automatic t_cascade();
    cmap = 8'h04; spres = 1'b1;
    raise(2); lower(2);
    do_ack();
    chk("R7 slave selected", {7'b0, ssel}, 8'h01);
    step();
    chk("R7 select one cycle", {7'b0, ssel}, 8'h00);
    do_eoi(1'b1, 3'd2);
    spres = 1'b0;
    raise(2); lower(2);
    do_ack();
    chk("R7 no slave present", {7'b0, ssel}, 8'h00);
    chk("R7 local vector", vec, 8'h42);
    do_eoi(1'b1, 3'd2);
    cmap = '0;
  endtask

  task automatic t_spurious();
    do_ack();
    chk("R9 spurious vector", vec, 8'h47);
    chk("R9 spurious no select", {7'b0, ssel}, 8'h00);
    chk("R9 state unchanged", {pend | isr}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_mask();
    t_priority();
    t_ceiling();
    t_auto();
    t_cascade();
    t_spurious();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule